// File: doc/BRIEF.md
# Burst Read Address Expander

This block lets a display pipeline fetch runs of consecutive memory words without buffering one address per word. The video side pushes a compact request made of a start address and a word count into a four-entry request queue. A counter takes the oldest request, steps through its addresses and offers one single-word read at a time to a memory arbiter. To the arbiter it looks like a read-address FIFO: a valid flag, a head address, and a grant that consumes the head.

Words coming back from memory go into a return FIFO that belongs to this block. The video logic drains that FIFO at scanout time and does not check whether it is empty before each pop. To keep returns from overrunning the FIFO, the block reserves one return slot for each granted read. It offers a new read only while the slots already reserved are fewer than the FIFO depth. The request queue is a plain synchronous FIFO, and both sides run on one clock.

Top module: `rd_burst_agent`

## Requirements
- R1: While rst_ni is low, and after it is released, mem_req_o, req_full_o, req_ovf_o are 0 and ret_level_o is 0.
- R2: The request queue holds REQ_DEPTH (4) entries and req_full_o is 1 while it holds that many. A push made while req_full_o is 1 is dropped and req_ovf_o is 1 for exactly the one cycle after that push edge. Otherwise req_ovf_o is 0.
- R3: An accepted request (A, N) results in exactly N grants at addresses A, A+1, …, A+N-1, taken modulo 2^AW. Requests are served in push order. While a burst runs, every grant that is followed by a request moves the address on by one.
- R4: Once mem_req_o is 1 without mem_gnt_i, it stays 1 on the next cycle and mem_addr_o keeps its value.
- R5: A request with N = 0 leaves the queue without mem_req_o ever rising for it.
- R6: A request pushed into an idle block can be granted at the second clock edge after its push edge. When a burst ends with its last grant and another request is queued, mem_req_o is low for exactly one cycle before the next burst starts.
- R7: The number of granted reads not yet popped by the video side never exceeds RET_DEPTH. mem_req_o is 0 while that number equals RET_DEPTH.
- R8: Words arriving on mem_rvalid_i/mem_rdata_i appear on ret_data_o in arrival order. ret_data_o shows the oldest stored word and ret_level_o gives the number of stored words.
- R9: ret_pop_i removes the oldest word at the clock edge without any empty check. Each pop frees one reserved slot. The video side must pop only while ret_level_o is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_push_i | input | 1 | Push a burst request |
| req_addr_i | input | AW | Start word address of the burst |
| req_len_i | input | LW | Number of words in the burst |
| req_full_o | output | 1 | Request queue full |
| req_ovf_o | output | 1 | Pulse: the previous push was dropped |
| mem_req_o | output | 1 | Read request valid toward the arbiter |
| mem_addr_o | output | AW | Current read address |
| mem_gnt_i | input | 1 | Arbiter takes the current address |
| mem_rvalid_i | input | 1 | Returned read word valid |
| mem_rdata_i | input | DW | Returned read word |
| ret_pop_i | input | 1 | Video side takes the oldest word (unqualified) |
| ret_data_o | output | DW | Oldest stored word |
| ret_level_o | output | RLW | Stored word count |

## Verification
Several properties are checked on every cycle:
- A dropped push produces the overflow pulse on the next cycle.
- A pending request stays stable until it is granted.
- Consecutive grants within a burst step the address by one.
- Granted-but-unpopped reads never pass the return depth, and the request is withheld at that limit.
- The return FIFO is never written while full.
- The video side never pops an empty FIFO.

Some behaviour only the bench scenarios can show:
- The exact sequence and count of addresses produced for each burst, including zero-length entries and wrap past the top of the address space.
- The one-cycle gap between bursts.
- The data order seen at scanout.
- That exactly as many new reads follow a pop as slots the pop freed.

// File: rtl/rba_pkg.sv
package rba_pkg;
  typedef enum logic {GATE_NONE, GATE_GUARD} gate_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rba_sync_fifo.sv
module rba_sync_fifo
  import rba_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned DEPTH     = 4,
  parameter gate_e       PUSH_GATE = GATE_GUARD,
  parameter gate_e       POP_GATE  = GATE_GUARD,
  localparam int unsigned PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVW      = cnt_w(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic [W-1:0]   wdata_i,
  input  logic           pop_i,
  output logic [W-1:0]   rdata_o,
  output logic           empty_o,
  output logic           full_o,
  output logic [LVW-1:0] level_o
);
  logic [W-1:0]   mem_q [DEPTH];
  logic [PW-1:0]  wr_ptr_q, rd_ptr_q;
  logic [LVW-1:0] level_q;
  logic           wr_en, rd_en;

  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LVW'(DEPTH));
  assign level_o = level_q;
  assign rdata_o = mem_q[rd_ptr_q];

  generate
    if (PUSH_GATE == GATE_GUARD) begin : g_wr_guard
      assign wr_en = push_i & ~full_o;
    end else begin : g_wr_free
      assign wr_en = push_i;
    end
    if (POP_GATE == GATE_GUARD) begin : g_rd_guard
      assign rd_en = pop_i & ~empty_o;
    end else begin : g_rd_free
      // consumer guarantees data is present
      assign rd_en = pop_i;
    end
  endgenerate

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= bump(wr_ptr_q);
      if (rd_en) rd_ptr_q <= bump(rd_ptr_q);
      case ({wr_en, rd_en})
        2'b10:   level_q <= level_q + LVW'(1);
        2'b01:   level_q <= level_q - LVW'(1);
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/rba_addr_ctr.sv
module rba_addr_ctr #(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          head_valid_i,
  input  logic [AW-1:0] head_addr_i,
  input  logic [LW-1:0] head_len_i,
  input  logic          credit_ok_i,
  input  logic          gnt_i,
  output logic          head_pop_o,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          adv_o
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] left_q;
  logic          busy;

  assign busy       = (left_q != '0);
  assign head_pop_o = ~busy & head_valid_i;
  assign req_o      = busy & credit_ok_i;
  assign adv_o      = req_o & gnt_i;
  assign addr_o     = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (head_pop_o) begin
      // zero-length heads load zero and are replaced next cycle
      addr_q <= head_addr_i;
      left_q <= head_len_i;
    end else if (adv_o) begin
      addr_q <= addr_q + AW'(1);
      left_q <= left_q - LW'(1);
    end
  end
endmodule

// File: rtl/rba_credit.sv
module rba_credit
  import rba_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = cnt_w(DEPTH)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic give_i,
  output logic ok_o
);
  logic [CW-1:0] resv_q;

  assign ok_o = (resv_q < CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resv_q <= '0;
    end else begin
      case ({take_i, give_i})
        2'b10:   resv_q <= resv_q + CW'(1);
        2'b01:   resv_q <= resv_q - CW'(1);
        default: resv_q <= resv_q;
      endcase
    end
  end
endmodule

// File: rtl/rd_burst_agent.sv
module rd_burst_agent
  import rba_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned LW        = 8,
  parameter int unsigned DW        = 32,
  parameter int unsigned REQ_DEPTH = 4,
  parameter int unsigned RET_DEPTH = 8,
  localparam int unsigned RLW      = cnt_w(RET_DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_push_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [LW-1:0]  req_len_i,
  output logic           req_full_o,
  output logic           req_ovf_o,
  output logic           mem_req_o,
  output logic [AW-1:0]  mem_addr_o,
  input  logic           mem_gnt_i,
  input  logic           mem_rvalid_i,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           ret_pop_i,
  output logic [DW-1:0]  ret_data_o,
  output logic [RLW-1:0] ret_level_o
);
  localparam int unsigned EW  = AW + LW;
  localparam int unsigned QLW = cnt_w(REQ_DEPTH);

  logic [EW-1:0]  q_head;
  logic           q_empty, q_pop, adv, credit_ok, ovf_q, ret_empty, ret_full;
  logic [QLW-1:0] q_level;

  rba_sync_fifo #(
    .W(EW), .DEPTH(REQ_DEPTH), .PUSH_GATE(GATE_GUARD), .POP_GATE(GATE_GUARD)
  ) u_req_q (
    .clk_i, .rst_ni,
    .push_i  (req_push_i),
    .wdata_i ({req_addr_i, req_len_i}),
    .pop_i   (q_pop),
    .rdata_o (q_head),
    .empty_o (q_empty),
    .full_o  (req_full_o),
    .level_o (q_level)
  );

  rba_addr_ctr #(.AW(AW), .LW(LW)) u_ctr (
    .clk_i, .rst_ni,
    .head_valid_i (~q_empty),
    .head_addr_i  (q_head[EW-1:LW]),
    .head_len_i   (q_head[LW-1:0]),
    .credit_ok_i  (credit_ok),
    .gnt_i        (mem_gnt_i),
    .head_pop_o   (q_pop),
    .req_o        (mem_req_o),
    .addr_o       (mem_addr_o),
    .adv_o        (adv)
  );

  rba_credit #(.DEPTH(RET_DEPTH)) u_credit (
    .clk_i, .rst_ni,
    .take_i (adv),
    .give_i (ret_pop_i),
    .ok_o   (credit_ok)
  );

  rba_sync_fifo #(
    .W(DW), .DEPTH(RET_DEPTH), .PUSH_GATE(GATE_NONE), .POP_GATE(GATE_NONE)
  ) u_ret_q (
    .clk_i, .rst_ni,
    .push_i  (mem_rvalid_i),
    .wdata_i (mem_rdata_i),
    .pop_i   (ret_pop_i),
    .rdata_o (ret_data_o),
    .empty_o (ret_empty),
    .full_o  (ret_full),
    .level_o (ret_level_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= req_push_i & req_full_o;
  end
  assign req_ovf_o = ovf_q;

  logic unused;
  assign unused = ^{q_level, ret_empty, ret_full};
endmodule

// File: rtl/rd_burst_agent_chk.sv
module rd_burst_agent_chk #(
  parameter int unsigned AW        = 16,
  parameter int unsigned RET_DEPTH = 8,
  parameter int unsigned RLW       = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_push_i,
  input logic           req_full_o,
  input logic           req_ovf_o,
  input logic           mem_req_o,
  input logic [AW-1:0]  mem_addr_o,
  input logic           mem_gnt_i,
  input logic           mem_rvalid_i,
  input logic           ret_pop_i,
  input logic [RLW-1:0] ret_level_o
);
  localparam int unsigned OW = $clog2(RET_DEPTH + 1) + 1;
  logic [OW-1:0] outst_q;
  logic          take;

  assign take = mem_req_o & mem_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else         outst_q <= outst_q + OW'(take) - OW'(ret_pop_i);
  end

  AST_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_push_i && req_full_o |=> req_ovf_o); // R2
  AST_OVF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_push_i && req_full_o) |=> !req_ovf_o); // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(1))); // R3
  AST_CREDIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q <= OW'(RET_DEPTH)); // R7
  AST_CREDIT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q == OW'(RET_DEPTH) |-> !mem_req_o); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i && !ret_pop_i |-> ret_level_o < RLW'(RET_DEPTH)); // R8
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_pop_i |-> ret_level_o != '0); // R9
endmodule

bind rd_burst_agent rd_burst_agent_chk #(
  .AW(AW), .RET_DEPTH(RET_DEPTH), .RLW(RLW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_push_i(req_push_i), .req_full_o(req_full_o),
  .req_ovf_o(req_ovf_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i), .ret_pop_i(ret_pop_i),
  .ret_level_o(ret_level_o)
);

// File: tb/rd_burst_agent_test.sv
`timescale 1ns/1ps
module rd_burst_agent_test;
  localparam int AW = 16, LW = 8, DW = 32, RET_DEPTH = 8, RLW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_push_i = 1'b0, mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0, ret_pop_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0, mem_addr_o;
  logic [LW-1:0] req_len_i = '0;
  logic [DW-1:0] mem_rdata_i = '0, ret_data_o;
  logic req_full_o, req_ovf_o, mem_req_o;
  logic [RLW-1:0] ret_level_o;

  always #4 clk_i = ~clk_i;

  rd_burst_agent #(.AW(AW), .LW(LW), .DW(DW), .REQ_DEPTH(4), .RET_DEPTH(RET_DEPTH)) uut (.*);

  int nchk = 0, nfail = 0, cyc = 0, ngnt = 0;
  int gnt_mode = 0, pop_mode = 0, pop_budget = 0;
  bit seen_req = 0;
  logic [AW-1:0] exp_addr[$];
  logic [DW-1:0] exp_data[$];
  int gcyc_q[$];
  logic pv[3];
  logic [DW-1:0] pd[3];
  int last_push_cyc = 0;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h @%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial for (int i = 0; i < 3; i++) begin pv[i] = 0; pd[i] = '0; end

  // arbiter, memory and scanout model
  always @(negedge clk_i) if (rst_ni) begin
    bit g, p;
    mem_rvalid_i = pv[2];
    mem_rdata_i  = pd[2];
    pv[2] = pv[1]; pd[2] = pd[1];
    pv[1] = pv[0]; pd[1] = pd[0];
    g = (gnt_mode == 2) || (gnt_mode == 1 && ($urandom % 10) < 7);
    mem_gnt_i = g;
    if (mem_req_o) seen_req = 1;
    pv[0] = 0;
    if (mem_req_o && g) begin
      ngnt++;
      gcyc_q.push_back(cyc + 1);
      if (exp_addr.size() == 0) check(0, "R3 unexpected grant", mem_addr_o, 0);
      else begin
        logic [AW-1:0] ea;
        ea = exp_addr.pop_front();
        check(mem_addr_o == ea, "R3 address", mem_addr_o, ea);
      end
      exp_data.push_back(mem_word(mem_addr_o));
      pv[0] = 1; pd[0] = mem_word(mem_addr_o);
    end
    p = (ret_level_o != 0) && (pop_budget > 0 || (pop_mode == 1 && ($urandom % 10) < 6));
    if (p) begin
      if (pop_budget > 0) pop_budget--;
      if (exp_data.size() == 0) check(0, "R8 unexpected data", ret_data_o, 0);
      else begin
        logic [DW-1:0] ed;
        ed = exp_data.pop_front();
        check(ret_data_o == ed, "R8 data order", ret_data_o, ed);
      end
    end
    ret_pop_i = p;
  end

  task automatic push(input logic [AW-1:0] a, input logic [LW-1:0] l);
    bit acc;
    @(negedge clk_i);
    acc = !req_full_o;
    req_push_i = 1; req_addr_i = a; req_len_i = l;
    last_push_cyc = cyc + 1;
    if (acc) for (int i = 0; i < int'(l); i++) exp_addr.push_back(AW'(a + i));
    @(posedge clk_i); #1;
    req_push_i = 0;
    check(req_ovf_o == !acc, "R2 overflow flag", req_ovf_o, !acc);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic drain();
    for (int k = 0; k < 4000 && (exp_addr.size() != 0 || exp_data.size() != 0); k++)
      @(posedge clk_i);
    wait_cyc(2);
    check(exp_addr.size() == 0 && exp_data.size() == 0, "R3 drain",
          exp_addr.size() + exp_data.size(), 0);
  endtask

  initial begin
    int base, first;
    void'($urandom(32'd7081));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!mem_req_o && !req_full_o && !req_ovf_o && ret_level_o == 0, "R1 in reset",
          {mem_req_o, req_full_o, req_ovf_o, ret_level_o}, 0);
    rst_ni = 1;
    wait_cyc(2);
    check(!mem_req_o && !req_full_o && !req_ovf_o && ret_level_o == 0, "R1 after reset",
          {mem_req_o, req_full_o, req_ovf_o, ret_level_o}, 0);

    // R6 timing
    gnt_mode = 2; pop_mode = 1;
    gcyc_q.delete();
    push(16'h0100, 2);
    first = last_push_cyc;
    push(16'h0200, 1);
    wait_cyc(10);
    check(gcyc_q.size() == 3, "R6 grant count", gcyc_q.size(), 3);
    if (gcyc_q.size() == 3) begin
      check(gcyc_q[0] - first == 2, "R6 idle latency", gcyc_q[0] - first, 2);
      check(gcyc_q[1] - gcyc_q[0] == 1, "R6 back to back", gcyc_q[1] - gcyc_q[0], 1);
      check(gcyc_q[2] - gcyc_q[1] == 2, "R6 burst gap", gcyc_q[2] - gcyc_q[1], 2);
    end
    drain();

    // R5 zero length
    seen_req = 0; base = ngnt;
    push(16'h0300, 0);
    wait_cyc(10);
    check(!seen_req, "R5 no request for empty burst", seen_req, 0);
    push(16'h0310, 0);
    push(16'h0320, 3);
    drain();
    check(ngnt - base == 3, "R5 grants after empty entry", ngnt - base, 3);

    // R2 full and dropped push
    gnt_mode = 0; base = ngnt;
    for (int i = 0; i < 5; i++) push(AW'(16'h1000 + 16'h40 * i), 3);
    check(req_full_o, "R2 full after four queued", req_full_o, 1);
    push(16'h2000, 5);
    wait_cyc(1);
    check(!req_ovf_o, "R2 overflow pulse one cycle", req_ovf_o, 0);
    gnt_mode = 2;
    drain();
    check(ngnt - base == 15, "R2 dropped push issued nothing", ngnt - base, 15);

    // R7 credit limit with wrap (R3), R9 pop frees slots
    pop_mode = 0; base = ngnt;
    push(16'hFFF8, 12);
    wait_cyc(30);
    check(ngnt - base == RET_DEPTH, "R7 grants stop at depth", ngnt - base, RET_DEPTH);
    check(!mem_req_o, "R7 request withheld", mem_req_o, 0);
    check(ret_level_o == RET_DEPTH, "R8 level full", ret_level_o, RET_DEPTH);
    pop_budget = 3;
    wait_cyc(20);
    check(ngnt - base == RET_DEPTH + 3, "R9 pops release credit", ngnt - base, RET_DEPTH + 3);
    check(ret_level_o == RET_DEPTH, "R9 level refilled", ret_level_o, RET_DEPTH);
    pop_mode = 1;
    drain();

    // random mix
    gnt_mode = 1;
    for (int n = 0; n < 150; n++) begin
      repeat ($urandom % 4) @(negedge clk_i);
      if (n % 25 == 0) push(AW'(16'hFFFF - ($urandom % 4)), LW'(2 + $urandom % 8));
      else             push(AW'($urandom), LW'($urandom % 10));
    end
    drain();
    wait_cyc(5);
    check(ret_level_o == 0 && !mem_req_o, "R8 idle at end", {mem_req_o, ret_level_o}, 0);
    finish_run();
  end
endmodule